// File: doc/BRIEF.md
# Memory controller performance counter unit

This block watches a DRAM controller and counts what it does. The controller drives a vector of single-cycle event strobes, plus one strobe for each DRAM read operation and one for each DRAM write operation. Eight programmable counters each pick their events through a bitmap. Two fixed counters follow the read and write strobes without pause.

Software reaches the unit through a 64-bit register port with valid, write, byte address and data signals. Read data comes back on the next cycle. A programmable counter counts only while two things are true: its own enable bit is set, and a counting session is open. A write to the start register opens a session and clears all programmable values. A write to the end register closes the session.

The fixed counters have their own enable register. They also have a clear register whose bits act as one-shot strobes. A programmable counter that reaches its top value stays there. A fixed counter rolls over to zero and records the rollover in a sticky flag.

Top module: `ddr_perf_monitor`

## Requirements
- R1: After reset every register reads zero. A read returns its data on `reg_rdata` in the cycle after the request, and the value holds until the next read. A read of an offset that is not mapped returns zero.
- R2: Programmable counter n has a configuration register at offset 0x8040 + 8·n. Bit 63 is its enable and bits EVT_W-1:0 hold its event bitmap. Any other written bit reads back as zero.
- R3: Event k (k from 1) is strobe bit k-1, and a bitmap bit selects the strobe with the same index. A power-state event selects a 4-bit group of adjacent bits. Counter n adds exactly one in each cycle in which its enable is set, a session is open, and at least one selected strobe is high. Strobes that are not selected do nothing.
- R4: Writing bit 0 = 1 to offset 0x8028 opens a session and clears all programmable values; counting resumes on the next cycle. Writing bit 0 = 1 to offset 0x8030 closes the session, and the values then hold. Offset 0x8028 reads bit 1 as the session-open flag.
- R5: Programmable value n reads at offset 0x8080 + 8·n and is CNT_W+1 bits wide. Once it reaches all ones it stays there until the next session start.
- R6: The fixed write counter reads at 0x80D0 and the fixed read counter at 0x80D8. In the register at 0x80C0, bit 0 enables the write counter and bit 1 enables the read counter. The fixed counters count whether or not a session is open.
- R7: In the register at 0x80C8, a written bit 0 clears the write counter and a written bit 1 clears the read counter, including its overflow flag. A clear wins over an increment in the same cycle. This register always reads zero.
- R8: A fixed counter's low CNT_W bits wrap to zero, and bit CNT_W is a sticky overflow flag set by that wrap.
- R9: Offset 0x8020 bit 0 is a manual-mode flag that reads back as written. Offset 0x8038 bit 0 is set when a session is ended while manual mode is off, and it is cleared by a session start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the request |
| evt_strobe | input | EVT_W | Per-cycle event strobes from the controller |
| dram_rd_op | input | 1 | One DRAM read operation this cycle |
| dram_wr_op | input | 1 | One DRAM write operation this cycle |

## Verification
On every cycle the assertions check the following for each counter:
- a programmable value moves by at most one;
- a value is frozen while no session is open;
- a saturated value stays pinned at its top;
- a start clears all programmable values and raises the session flag;
- a clear strobe zeroes its fixed counter;
- an unmapped read returns zero.

Some behaviour needs the bench's scenarios instead. These are which strobes a bitmap actually selects, including the 4-bit power-state group, and the exact counts reached. They also cover end-status under the two modes, and the cycle-level meeting of a clear with an increment. The last is the wrap value with its sticky flag, run at a narrow counter width.

// File: rtl/ddrpm_pkg.sv
// Package: register offsets and bit positions shared by the counter unit.
// Assumes 8-byte aligned 64-bit registers in a 16-bit byte offset space.
package ddrpm_pkg;
    localparam logic [15:0] OFF_MODE   = 16'h8020;
    localparam logic [15:0] OFF_START  = 16'h8028;
    localparam logic [15:0] OFF_END    = 16'h8030;
    localparam logic [15:0] OFF_ESTAT  = 16'h8038;
    localparam logic [15:0] OFF_CFG0   = 16'h8040;
    localparam logic [15:0] OFF_VAL0   = 16'h8080;
    localparam logic [15:0] OFF_FREN   = 16'h80C0;
    localparam logic [15:0] OFF_FRCLR  = 16'h80C8;
    localparam logic [15:0] OFF_WRVAL  = 16'h80D0;
    localparam logic [15:0] OFF_RDVAL  = 16'h80D8;
    localparam int          CFG_EN_BIT = 63;
    localparam int          REG_STRIDE = 8;

    // Index of the two fixed counters inside the enable/clear fields
    typedef enum int {FIX_WRITE = 0, FIX_READ = 1} fix_idx_e;
endpackage

// File: rtl/ddrpm_regs.sv
// Register file and decode for the counter unit.
// Holds per-counter configuration, session state, mode, end status and the
// fixed-counter enables; builds the one-shot start and clear strobes and the
// registered read path. Assumes one access per cycle, byte offsets aligned.
module ddrpm_regs #(
    parameter int NUM_PROG = 8,
    parameter int EVT_W    = 56,
    parameter int CNT_W    = 48
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_valid,
    input  logic                            reg_write,
    input  logic [15:0]                     reg_addr,
    input  logic [63:0]                     reg_wdata,
    output logic [63:0]                     reg_rdata,
    input  logic [NUM_PROG-1:0][CNT_W:0]    prog_vals,
    input  logic [CNT_W:0]                  wr_val,
    input  logic [CNT_W:0]                  rd_val,
    output logic [NUM_PROG-1:0]             cfg_en,
    output logic [NUM_PROG-1:0][EVT_W-1:0]  cfg_map,
    output logic                            sess_active,
    output logic                            start_pulse,
    output logic [1:0]                      fr_en,
    output logic [1:0]                      fr_clr
);
    import ddrpm_pkg::*;

    logic        wr_hit, rd_hit, end_pulse;
    logic        mode_manual, end_stat;
    logic [63:0] rd_mux;

    // Decode of write strobes for this cycle
    always_comb begin
        wr_hit      = reg_valid && reg_write;
        rd_hit      = reg_valid && !reg_write;
        start_pulse = wr_hit && (reg_addr == OFF_START) && reg_wdata[0];
        end_pulse   = wr_hit && (reg_addr == OFF_END) && reg_wdata[0];
        fr_clr      = (wr_hit && (reg_addr == OFF_FRCLR)) ? reg_wdata[1:0] : 2'b00;
    end

    // Per-counter enable and event bitmap storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en  <= '0;
            cfg_map <= '0;
        end else if (wr_hit) begin
            for (int i = 0; i < NUM_PROG; i++) begin
                if (reg_addr == OFF_CFG0 + 16'(REG_STRIDE * i)) begin
                    cfg_en[i]  <= reg_wdata[CFG_EN_BIT];
                    cfg_map[i] <= reg_wdata[EVT_W-1:0];
                end
            end
        end
    end

    // Session open/close, mode flag, end status and fixed-counter enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_active <= 1'b0;
            mode_manual <= 1'b0;
            end_stat    <= 1'b0;
            fr_en       <= 2'b00;
        end else begin
            if (start_pulse) begin
                sess_active <= 1'b1;
                end_stat    <= 1'b0;
            end else if (end_pulse) begin
                sess_active <= 1'b0;
                if (!mode_manual) end_stat <= 1'b1;
            end
            if (wr_hit && reg_addr == OFF_MODE) mode_manual <= reg_wdata[0];
            if (wr_hit && reg_addr == OFF_FREN) fr_en <= reg_wdata[1:0];
        end
    end

    // Read selection from the current register and counter state
    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            OFF_MODE:  rd_mux = {63'd0, mode_manual};
            OFF_START: rd_mux = {62'd0, sess_active, 1'b0};
            OFF_ESTAT: rd_mux = {63'd0, end_stat};
            OFF_FREN:  rd_mux = {62'd0, fr_en};
            OFF_WRVAL: rd_mux = 64'(wr_val);
            OFF_RDVAL: rd_mux = 64'(rd_val);
            default:   rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_PROG; i++) begin
            if (reg_addr == OFF_CFG0 + 16'(REG_STRIDE * i))
                rd_mux = {cfg_en[i], (63 - EVT_W)'(0), cfg_map[i]};
            if (reg_addr == OFF_VAL0 + 16'(REG_STRIDE * i))
                rd_mux = 64'(prog_vals[i]);
        end
    end

    // Registered read data, updated only by read requests
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_hit) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/ddrpm_prog_ctr.sv
// One programmable counter: adds one per cycle when any selected strobe is
// high and counting is allowed, saturates at all ones, cleared by a start.
// Assumes clr and run come from the register block in the same cycle.
module ddrpm_prog_ctr #(
    parameter int EVT_W = 56,
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [EVT_W-1:0] sel_map,
    input  logic [EVT_W-1:0] evt,
    output logic [CNT_W:0]   value
);
    localparam logic [CNT_W:0] TOP = '1;

    logic hit;

    // Any selected strobe active this cycle
    always_comb hit = |(sel_map & evt);

    // Count, saturate and clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                    value <= '0;
        else if (run && hit && value != TOP)  value <= value + 1'b1;
    end
endmodule

// File: rtl/ddrpm_free_ctr.sv
// One fixed free-running counter: CNT_W-bit wrapping count plus a sticky
// overflow flag on top. Clear has priority over an increment.
module ddrpm_free_ctr #(
    parameter int CNT_W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           inc,
    output logic [CNT_W:0] value
);
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic [CNT_W:0]   sum;

    // Next count with carry out of the top bit
    always_comb sum = {1'b0, cnt} + 1'b1;

    // Wrap count and latch the overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en && inc) begin
            cnt <= sum[CNT_W-1:0];
            if (sum[CNT_W]) ovf <= 1'b1;
        end
    end

    // Flag above the count
    always_comb value = {ovf, cnt};
endmodule

// File: rtl/ddr_perf_monitor.sv
// Top of the memory controller performance counter unit.
// Ties the register block to NUM_PROG programmable counters and the two fixed
// counters. Assumes event strobes are synchronous to clk.
module ddr_perf_monitor #(
    parameter int NUM_PROG = 8,
    parameter int EVT_W    = 56,
    parameter int CNT_W    = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [15:0]      reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic [EVT_W-1:0] evt_strobe,
    input  logic             dram_rd_op,
    input  logic             dram_wr_op
);
    import ddrpm_pkg::*;

    logic [NUM_PROG-1:0][CNT_W:0]   prog_vals;
    logic [NUM_PROG-1:0]            cfg_en;
    logic [NUM_PROG-1:0][EVT_W-1:0] cfg_map;
    logic                           sess_active, start_pulse;
    logic [1:0]                     fr_en, fr_clr, fr_inc;
    logic [1:0][CNT_W:0]            fix_vals;
    logic [CNT_W:0]                 wr_val, rd_val;

    ddrpm_regs #(.NUM_PROG(NUM_PROG), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prog_vals(prog_vals), .wr_val(wr_val), .rd_val(rd_val),
        .cfg_en(cfg_en), .cfg_map(cfg_map), .sess_active(sess_active),
        .start_pulse(start_pulse), .fr_en(fr_en), .fr_clr(fr_clr)
    );

    // Programmable counter array
    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
        ddrpm_prog_ctr #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(start_pulse),
            .run(sess_active && cfg_en[g]), .sel_map(cfg_map[g]),
            .evt(evt_strobe), .value(prog_vals[g])
        );
    end

    // Fixed counters: index FIX_WRITE and FIX_READ
    always_comb begin
        fr_inc[FIX_WRITE] = dram_wr_op;
        fr_inc[FIX_READ]  = dram_rd_op;
    end

    for (genvar f = 0; f < 2; f++) begin : g_fix
        ddrpm_free_ctr #(.CNT_W(CNT_W)) u_fix (
            .clk(clk), .rst_n(rst_n), .clr(fr_clr[f]), .en(fr_en[f]),
            .inc(fr_inc[f]), .value(fix_vals[f])
        );
    end

    always_comb begin
        wr_val = fix_vals[FIX_WRITE];
        rd_val = fix_vals[FIX_READ];
    end
endmodule

// File: rtl/ddrpm_checks.sv
// Checker for the counter unit, bound into the top. Relates the register
// port, session state and counter values across cycles.
module ddrpm_checks #(
    parameter int NUM_PROG = 8,
    parameter int CNT_W    = 48
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_valid,
    input logic                         reg_write,
    input logic [15:0]                  reg_addr,
    input logic [63:0]                  reg_rdata,
    input logic                         start_pulse,
    input logic                         sess_active,
    input logic [NUM_PROG-1:0][CNT_W:0] prog_vals,
    input logic [1:0]                   fr_clr,
    input logic [CNT_W:0]               wr_val,
    input logic [CNT_W:0]               rd_val
);
    localparam logic [CNT_W:0] TOP = '1;

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && (reg_addr < 16'h8020 || reg_addr >= 16'h80E0))
        |=> (reg_rdata == 64'd0));

    p_session_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> sess_active);

    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_clr[0] |=> (wr_val == '0));

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_clr[1] |=> (rd_val == '0));

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_prop
        p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            start_pulse |=> (prog_vals[i] == '0));

        p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !start_pulse |=> (prog_vals[i] == $past(prog_vals[i]) ||
                              prog_vals[i] == $past(prog_vals[i]) + 1'b1));

        p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sess_active && !start_pulse) |=> $stable(prog_vals[i]));

        p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_vals[i] == TOP && !start_pulse) |=> (prog_vals[i] == TOP));
    end
endmodule

bind ddr_perf_monitor ddrpm_checks #(.NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .start_pulse(start_pulse),
    .sess_active(sess_active), .prog_vals(prog_vals), .fr_clr(fr_clr),
    .wr_val(wr_val), .rd_val(rd_val)
);

// File: tb/test_ddr_perf_monitor.sv
// Bench: behavioural reference model stepped on every clock and compared
// against reg_rdata, plus directed scenarios with hand-computed values.
module test_ddr_perf_monitor;
    localparam int NP = 8;
    localparam int EW = 56;
    localparam int CW = 8;
    localparam longint PMAX = (64'd1 << (CW + 1)) - 1;
    localparam longint FMOD = 64'd1 << CW;

    logic        clk = 0, rst_n = 0;
    logic        b_valid = 0, b_write = 0, b_rd = 0, b_wr = 0;
    logic [15:0] b_addr = 0;
    logic [63:0] b_wdata = 0;
    logic [EW-1:0] b_evt = 0;
    logic [63:0] reg_rdata;

    int errors = 0, checks = 0;
    bit finished = 0;

    ddr_perf_monitor #(.NUM_PROG(NP), .EVT_W(EW), .CNT_W(CW)) i_ddr_perf_monitor (
        .clk(clk), .rst_n(rst_n), .reg_valid(b_valid), .reg_write(b_write),
        .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(reg_rdata),
        .evt_strobe(b_evt), .dram_rd_op(b_rd), .dram_wr_op(b_wr)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    logic [EW-1:0] m_map[NP];
    bit            m_en[NP];
    longint        m_prog[NP];
    bit            m_active, m_mode, m_estat;
    bit [1:0]      m_fren;
    longint        m_fcnt[2];
    bit            m_fovf[2];
    logic [63:0]   m_rdata;
    logic [15:0]   m_last_addr;

    function automatic logic [63:0] mread(input logic [15:0] a);
        int idx;
        if (a[2:0] != 0) return 64'd0;
        if (a >= 16'h8040 && a < 16'h8040 + 8 * NP) begin
            idx = (a - 16'h8040) / 8;
            return {m_en[idx], 7'd0, m_map[idx]};
        end
        if (a >= 16'h8080 && a < 16'h8080 + 8 * NP) begin
            idx = (a - 16'h8080) / 8;
            return 64'(m_prog[idx]);
        end
        case (a)
            16'h8020: return {63'd0, m_mode};
            16'h8028: return {62'd0, m_active, 1'b0};
            16'h8038: return {63'd0, m_estat};
            16'h80C0: return {62'd0, m_fren};
            16'h80D0: return 64'(m_fcnt[0]) | (64'(m_fovf[0]) << CW);
            16'h80D8: return 64'(m_fcnt[1]) | (64'(m_fovf[1]) << CW);
            default:  return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] a);
        if (a >= 16'h8040 && a < 16'h8080) return "R2";
        if (a >= 16'h8080 && a < 16'h80C0) return "R3";
        if (a == 16'h8028 || a == 16'h8030) return "R4";
        if (a == 16'h80C0 || a == 16'h80D0 || a == 16'h80D8) return "R6";
        if (a == 16'h80C8) return "R7";
        if (a == 16'h8020 || a == 16'h8038) return "R9";
        return "R1";
    endfunction

    // Model step on each rising edge, using state from before the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_map[i] = 0; m_en[i] = 0; m_prog[i] = 0; end
            m_active = 0; m_mode = 0; m_estat = 0; m_fren = 0;
            for (int j = 0; j < 2; j++) begin m_fcnt[j] = 0; m_fovf[j] = 0; end
            m_rdata = 0; m_last_addr = 0;
        end else begin
            bit [1:0] clr;
            bit [1:0] inc;
            if (b_valid && !b_write) begin
                m_rdata = mread(b_addr);
                m_last_addr = b_addr;
            end
            for (int i = 0; i < NP; i++)
                if (m_active && m_en[i] && ((m_map[i] & b_evt) != 0) && m_prog[i] < PMAX)
                    m_prog[i]++;
            clr = (b_valid && b_write && b_addr == 16'h80C8) ? b_wdata[1:0] : 2'b00;
            inc = {b_rd, b_wr};
            for (int j = 0; j < 2; j++) begin
                if (clr[j]) begin m_fcnt[j] = 0; m_fovf[j] = 0; end
                else if (m_fren[j] && inc[j]) begin
                    m_fcnt[j]++;
                    if (m_fcnt[j] == FMOD) begin m_fcnt[j] = 0; m_fovf[j] = 1; end
                end
            end
            if (b_valid && b_write) begin
                if (b_addr >= 16'h8040 && b_addr < 16'h8040 + 8 * NP && b_addr[2:0] == 0) begin
                    m_en[(b_addr - 16'h8040) / 8]  = b_wdata[63];
                    m_map[(b_addr - 16'h8040) / 8] = b_wdata[EW-1:0];
                end
                if (b_addr == 16'h8028 && b_wdata[0]) begin
                    m_active = 1; m_estat = 0;
                    for (int i = 0; i < NP; i++) m_prog[i] = 0;
                end
                if (b_addr == 16'h8030 && b_wdata[0]) begin
                    if (!m_mode) m_estat = 1;
                    m_active = 0;
                end
                if (b_addr == 16'h8020) m_mode = b_wdata[0];
                if (b_addr == 16'h80C0) m_fren = b_wdata[1:0];
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (reg_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s model compare: got %h expected %h", tag_of(m_last_addr), reg_rdata, m_rdata);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk); b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
        @(negedge clk); b_valid = 0; b_write = 0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk); b_valid = 1; b_write = 0; b_addr = a;
        @(negedge clk); b_valid = 0;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic evt_for(input logic [EW-1:0] v, input int n);
        @(negedge clk); b_evt = v;
        repeat (n) @(negedge clk);
        b_evt = 0;
    endtask

    localparam logic [63:0] EN = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values and unmapped offsets
        rd_chk(16'h8020, 0, "R1");
        rd_chk(16'h8028, 0, "R1");
        rd_chk(16'h8040, 0, "R1");
        rd_chk(16'h8080, 0, "R1");
        rd_chk(16'h80D0, 0, "R1");
        rd_chk(16'h9000, 0, "R1");
        rd_chk(16'h0000, 0, "R1");
        // R2: config readback masks unused bits (bit 60 dropped)
        wr(16'h8040, EN | (64'd1 << 60) | (64'd1 << 2));
        rd_chk(16'h8040, EN | (64'd1 << 2), "R2");
        wr(16'h8048, EN | (64'hF << 26));   // power-state 4-bit group
        wr(16'h8058, 64'd1 << 2);           // selected but not enabled
        // R4: start, active flag
        wr(16'h8028, 1);
        rd_chk(16'h8028, 2, "R4");
        // R3: selection, coincident strobes, masking, enable gating
        evt_for(56'd1 << 2, 5);
        evt_for(56'd1 << 28, 3);
        evt_for((56'd1 << 2) | (56'd1 << 10), 2);
        evt_for(56'd1 << 10, 4);
        rd_chk(16'h8080, 7, "R3");
        rd_chk(16'h8088, 3, "R3");
        rd_chk(16'h8098, 0, "R3");
        // R4: end holds values; R9 end status in non-manual mode
        wr(16'h8030, 1);
        evt_for(56'd1 << 2, 4);
        rd_chk(16'h8080, 7, "R4");
        rd_chk(16'h8028, 0, "R4");
        rd_chk(16'h8038, 1, "R9");
        // R9: manual mode; R4 start clears
        wr(16'h8020, 1);
        rd_chk(16'h8020, 1, "R9");
        wr(16'h8028, 1);
        rd_chk(16'h8080, 0, "R4");
        rd_chk(16'h8038, 0, "R9");
        wr(16'h8030, 1);
        rd_chk(16'h8038, 0, "R9");
        // R5: saturation at all ones
        wr(16'h8028, 1);
        evt_for(56'd1 << 2, 600);
        rd_chk(16'h8080, PMAX, "R5");
        evt_for(56'd1 << 2, 3);
        rd_chk(16'h8080, PMAX, "R5");
        wr(16'h8030, 1);
        // R6: fixed counters, independent enables, no session needed
        wr(16'h80C0, 1);
        @(negedge clk); b_wr = 1; b_rd = 1;
        repeat (10) @(negedge clk);
        b_wr = 0; b_rd = 0;
        rd_chk(16'h80D0, 10, "R6");
        rd_chk(16'h80D8, 0, "R6");
        wr(16'h80C0, 3);
        @(negedge clk); b_rd = 1;
        repeat (5) @(negedge clk);
        b_rd = 0;
        rd_chk(16'h80D8, 5, "R6");
        // R7: clear wins over a same-cycle increment; reads zero
        @(negedge clk); b_wr = 1;
        wr(16'h80C8, 1);
        repeat (2) @(negedge clk);
        b_wr = 0;
        rd_chk(16'h80D0, 2, "R7");
        rd_chk(16'h80D8, 5, "R7");
        rd_chk(16'h80C8, 0, "R7");
        // R8: wrap with sticky overflow
        wr(16'h80C8, 1);
        @(negedge clk); b_wr = 1;
        repeat (260) @(negedge clk);
        b_wr = 0;
        rd_chk(16'h80D0, (64'd1 << CW) | 64'd4, "R8");
        wr(16'h80C8, 2);
        rd_chk(16'h80D8, 0, "R7");
        rd_chk(16'h80D0, (64'd1 << CW) | 64'd4, "R8");
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule